// File: doc/BRIEF.md
# Ethernet Link Status LED Driver

This block turns the status reported by an Ethernet PHY into three active-low indicator lamps: one for the line rate, one for link presence combined with traffic, and one for duplex. Each lamp pin behaves as an open-drain output: the block either pulls the pin low, which lights the lamp, or lets it float high through an external pull-up.

The link/traffic lamp is lit steadily while a link is up. When transmit or receive traffic is reported, the lamp goes dark for a fixed off phase and is then guaranteed a lit minimum-on phase before traffic can darken it again. Traffic that arrives during either phase is remembered, so a new off phase begins right after the minimum-on phase ends. Both phase lengths are counted in ticks from a divider on the system clock, so every interval scales with parameters.

A mode input hands the pins over to general-purpose I/O. In that mode every lamp output is released and the traffic sequencer is held at rest.

Top module: `led_status_drv`

## Requirements
- R1: The speed lamp (bit 0 of `led_pull`) is pulled low when the line runs at 100 Mb/s or while auto-negotiation is in progress, provided the line is not isolated.
- R2: The speed lamp is released when the line runs at 10 Mb/s with no auto-negotiation in progress, and whenever the line is isolated.
- R3: The link/traffic lamp (bit 1) is pulled low while the link is up and no off phase is running.
- R4: With the link up and the sequencer idle, traffic on `tx_act` or `rx_act` in one cycle releases the link/traffic lamp from the next output update for exactly TICKS_OFF*CLK_PER_TICK cycles.
- R5: Each off phase is followed by a lit minimum-on phase of exactly TICKS_ON*CLK_PER_TICK cycles, and traffic during it does not shorten that phase.
- R6: Traffic seen during an off or minimum-on phase is held pending; when it is pending at the end of the minimum-on phase, a new off phase begins in the next cycle with no idle gap.
- R7: The duplex lamp (bit 2) is pulled low while the link is up and running full duplex.
- R8: When the link drops, the link/traffic and duplex lamps are released at the next output update, pending traffic is discarded and the sequencer returns to idle, so the lamp is lit steadily once the link returns.
- R9: In general-purpose mode (`gpio_mode` = 1) all three lamps are released and the sequencer is held idle; after leaving that mode no stale off phase remains.
- R10: Outputs are registered one clock after the inputs, and each pin level `led_pin[i]` is 0 exactly when `led_pull[i]` is 1, and 1 otherwise; after reset all pins are released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gpio_mode | input | 1 | 1 hands the pins to general-purpose I/O |
| link_up | input | 1 | PHY reports a valid link |
| speed_100 | input | 1 | 1 for 100 Mb/s, 0 for 10 Mb/s |
| aneg_busy | input | 1 | Auto-negotiation in progress |
| isolate | input | 1 | Line is electrically isolated |
| full_dup | input | 1 | Link runs full duplex |
| tx_act | input | 1 | Transmit activity pulse |
| rx_act | input | 1 | Receive activity pulse |
| led_pull | output | 3 | Pull-down enable per lamp: bit 0 speed, bit 1 link/traffic, bit 2 duplex |
| led_pin | output | 3 | Resolved pin level per lamp with an external pull-up |

## Verification
The static lamps are swept over all 64 combinations of mode, link, rate, negotiation, isolation and duplex, which separates the isolation override from the negotiation override and shows that duplex depends on link. The traffic lamp is followed cycle by cycle after a single pulse, after a second pulse placed in the off phase, in the middle of the minimum-on phase, on its last cycle and just after it, which tells a pending restart apart from a fresh start from idle. Link loss and general-purpose mode are each applied in the middle of a blink with traffic pending, showing that the remembered traffic is discarded rather than replayed.

// File: rtl/led_pkg.sv
package led_pkg;
   localparam int NUM_LEDS   = 3;
   localparam int LED_SPEED  = 0;
   localparam int LED_LINK   = 1;
   localparam int LED_DUPLEX = 2;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_OFF   = 2'd1,
      SEQ_MINON = 2'd2
   } seq_st_e;
endpackage

// File: rtl/led_tick_div.sv
module led_tick_div #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int unsigned W = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [W-1:0] LAST = W'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("led_tick_div: DIV must be at least 2");
   end

   logic [W-1:0] cnt_q;

   assign tick = (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr)    cnt_q <= '0;
      else if (tick)   cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   // R4: ticks are separated, so phase lengths are whole multiples of DIV
   p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R5: after a clear the divider needs a full period before the next tick
   p_clr_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !tick);
endmodule

// File: rtl/led_act_seq.sv
module led_act_seq
   import led_pkg::*;
#(
   parameter int unsigned CLK_PER_TICK = 4,
   parameter int unsigned TICKS_OFF    = 3,
   parameter int unsigned TICKS_ON     = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic act,
   output logic blank
);
   localparam int unsigned PMAX = (TICKS_OFF > TICKS_ON) ? TICKS_OFF : TICKS_ON;
   localparam int unsigned PW   = (PMAX > 2) ? $clog2(PMAX) : 1;
   localparam logic [PW-1:0] OFF_LAST = PW'(TICKS_OFF - 1);
   localparam logic [PW-1:0] ON_LAST  = PW'(TICKS_ON - 1);

   if (TICKS_OFF < 1 || TICKS_ON < 1) begin : g_bad_ticks
      $error("led_act_seq: phase lengths must be at least one tick");
   end

   seq_st_e       st_q, st_d;
   logic [PW-1:0] ph_q, ph_d;
   logic          pend_q, pend_d;
   logic          start;
   logic          tick;

   led_tick_div #(.DIV(CLK_PER_TICK)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start),
      .tick  (tick)
   );

   always_comb begin
      st_d   = st_q;
      ph_d   = ph_q;
      pend_d = pend_q;
      start  = 1'b0;
      if (hold) begin
         st_d   = SEQ_IDLE;
         ph_d   = '0;
         pend_d = 1'b0;
      end else begin
         unique case (st_q)
            SEQ_IDLE: begin
               if (act) begin
                  st_d  = SEQ_OFF;
                  ph_d  = '0;
                  start = 1'b1;
               end
            end
            SEQ_OFF: begin
               if (act) pend_d = 1'b1;
               if (tick) begin
                  if (ph_q == OFF_LAST) begin
                     st_d = SEQ_MINON;
                     ph_d = '0;
                  end else begin
                     ph_d = ph_q + 1'b1;
                  end
               end
            end
            SEQ_MINON: begin
               if (act) pend_d = 1'b1;
               if (tick) begin
                  if (ph_q == ON_LAST) begin
                     ph_d = '0;
                     if (pend_q || act) begin
                        st_d   = SEQ_OFF;
                        pend_d = 1'b0;
                        start  = 1'b1;
                     end else begin
                        st_d = SEQ_IDLE;
                     end
                  end else begin
                     ph_d = ph_q + 1'b1;
                  end
               end
            end
            default: begin
               st_d   = SEQ_IDLE;
               ph_d   = '0;
               pend_d = 1'b0;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SEQ_IDLE;
         ph_q   <= '0;
         pend_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         ph_q   <= ph_d;
         pend_q <= pend_d;
      end
   end

   assign blank = (st_q == SEQ_OFF);

   // R8 / R9: holding forces rest and drops remembered traffic
   p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (st_q == SEQ_IDLE && !pend_q));

   // R4: traffic while idle starts an off phase
   p_idle_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SEQ_IDLE && !hold && act) |=> (st_q == SEQ_OFF));

   // R5: an off phase never ends straight into idle
   p_off_to_minon_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SEQ_OFF && !hold) |=> (st_q == SEQ_OFF || st_q == SEQ_MINON));

   // R6: pending traffic during minimum-on never falls back to idle
   p_pend_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SEQ_MINON && pend_q && !hold) |=> (st_q == SEQ_OFF || st_q == SEQ_MINON));

   // R5: the phase counter stays inside the longest phase
   p_phase_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(ph_q) < PMAX));
endmodule

// File: rtl/led_od_stage.sv
module led_od_stage #(
   parameter int unsigned WIDTH   = 3,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] want,
   output logic [WIDTH-1:0] pull,
   output logic [WIDTH-1:0] pin
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (OUT_REG) begin : g_reg
         logic pull_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pull_q <= 1'b0;
            else        pull_q <= want[i];
         end
         assign pull[i] = pull_q;
      end else begin : g_comb
         assign pull[i] = want[i];
      end
      assign pin[i] = pull[i] ? 1'b0 : 1'b1;
   end
endmodule

// File: rtl/led_status_drv.sv
module led_status_drv
   import led_pkg::*;
#(
   parameter int unsigned CLK_PER_TICK = 25000,
   parameter int unsigned TICKS_OFF    = 80,
   parameter int unsigned TICKS_ON     = 80,
   parameter bit          OUT_REG      = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                gpio_mode,
   input  logic                link_up,
   input  logic                speed_100,
   input  logic                aneg_busy,
   input  logic                isolate,
   input  logic                full_dup,
   input  logic                tx_act,
   input  logic                rx_act,
   output logic [NUM_LEDS-1:0] led_pull,
   output logic [NUM_LEDS-1:0] led_pin
);
   logic                hold;
   logic                blank;
   logic [NUM_LEDS-1:0] want;

   assign hold = gpio_mode || !link_up;

   led_act_seq #(
      .CLK_PER_TICK (CLK_PER_TICK),
      .TICKS_OFF    (TICKS_OFF),
      .TICKS_ON     (TICKS_ON)
   ) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (hold),
      .act   (tx_act || rx_act),
      .blank (blank)
   );

   always_comb begin
      want = '0;
      if (!gpio_mode) begin
         want[LED_SPEED]  = !isolate && (speed_100 || aneg_busy);
         want[LED_LINK]   = link_up && !blank;
         want[LED_DUPLEX] = link_up && full_dup;
      end
   end

   led_od_stage #(
      .WIDTH   (NUM_LEDS),
      .OUT_REG (OUT_REG)
   ) u_od (
      .clk   (clk),
      .rst_n (rst_n),
      .want  (want),
      .pull  (led_pull),
      .pin   (led_pin)
   );

   if (OUT_REG) begin : g_port_chk
      // R9: general-purpose mode releases every lamp
      p_gpio_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
         gpio_mode |=> (led_pull == '0));

      // R1: fast rate or negotiation lights the speed lamp unless isolated
      p_speed_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (!gpio_mode && !isolate && (speed_100 || aneg_busy)) |=> led_pull[LED_SPEED]);

      // R2: isolation always darkens the speed lamp
      p_speed_iso_r2: assert property (@(posedge clk) disable iff (!rst_n)
         isolate |=> !led_pull[LED_SPEED]);

      // R8: link loss darkens link and duplex lamps at the next update
      p_link_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !link_up |=> (!led_pull[LED_LINK] && !led_pull[LED_DUPLEX]));

      // R7: full duplex on a live link lights the duplex lamp
      p_duplex_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (!gpio_mode && link_up && full_dup) |=> led_pull[LED_DUPLEX]);
   end
endmodule

// File: tb/tb_led_status_drv.sv
`timescale 1ns/1ps
module tb_led_status_drv;
   localparam int C   = 4;
   localparam int TO  = 3;
   localparam int TN  = 2;
   localparam int OFFC = TO * C;
   localparam int ONC  = TN * C;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       gpio_mode = 1'b0, link_up = 1'b0, speed_100 = 1'b0;
   logic       aneg_busy = 1'b0, isolate = 1'b0, full_dup = 1'b0;
   logic       tx_act = 1'b0, rx_act = 1'b0;
   logic [2:0] led_pull, led_pin;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   led_status_drv #(
      .CLK_PER_TICK (C),
      .TICKS_OFF    (TO),
      .TICKS_ON     (TN),
      .OUT_REG      (1'b1)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .gpio_mode (gpio_mode),
      .link_up   (link_up),
      .speed_100 (speed_100),
      .aneg_busy (aneg_busy),
      .isolate   (isolate),
      .full_dup  (full_dup),
      .tx_act    (tx_act),
      .rx_act    (rx_act),
      .led_pull  (led_pull),
      .led_pin   (led_pin)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic rest(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   // Single pulse at k=0, optional second pulse at k=p; restart at r (or none).
   task automatic act_run(input int p, input int r, input int len, input string tag);
      tx_act = 1'b1;
      step();
      tx_act = 1'b0;
      for (int k = 1; k <= len; k++) begin
         rx_act = (k == p);
         step();
         rx_act = 1'b0;
         begin
            logic off;
            off = (k >= 1 && k <= OFFC) || (r >= 0 && k >= r + 1 && k <= r + OFFC);
            chk(led_pin[1], off, tag);
            chk(led_pin[1], ~led_pull[1], "R10 pin vs pull");
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      rest(3);
      // R10: reset releases everything
      for (int i = 0; i < 3; i++) chk(led_pin[i], 1'b1, "R10 reset level");
      rst_n = 1'b1;
      step();
      for (int i = 0; i < 3; i++) chk(led_pin[i], 1'b1, "R10 idle after reset");

      // R1 R2 R7 R9: sweep static inputs
      for (int v = 0; v < 64; v++) begin
         logic e_spd, e_lnk, e_dup;
         {gpio_mode, link_up, speed_100, aneg_busy, isolate, full_dup} = 6'(v);
         step();
         e_spd = gpio_mode | isolate | ~(speed_100 | aneg_busy);
         e_lnk = gpio_mode | ~link_up;
         e_dup = gpio_mode | ~(link_up & full_dup);
         chk(led_pin[0], e_spd, "R1/R2 speed sweep");
         chk(led_pin[1], e_lnk, "R3/R9 link sweep");
         chk(led_pin[2], e_dup, "R7/R9 duplex sweep");
      end

      {gpio_mode, link_up, speed_100, aneg_busy, isolate, full_dup} = 6'b010001;
      rest(4);

      act_run(-1, -1, 30, "R4/R5 single pulse");
      rest(30);
      act_run(5, 20, 48, "R6 pending from off phase");
      rest(30);
      act_run(16, 20, 48, "R5/R6 pending from min-on");
      rest(30);
      act_run(20, 20, 48, "R6 pulse on last min-on cycle");
      rest(30);
      act_run(21, 21, 48, "R4 fresh start from idle");
      rest(30);

      // R8: link loss with traffic pending
      tx_act = 1'b1; step(); tx_act = 1'b0;
      for (int k = 1; k <= 40; k++) begin
         rx_act  = (k == 3);
         if (k == 6)  link_up = 1'b0;
         if (k == 10) link_up = 1'b1;
         step();
         rx_act = 1'b0;
         chk(led_pin[1], (k <= 9), "R8 link loss discards blink");
         chk(led_pin[2], (k >= 6 && k <= 9), "R8 duplex released on loss");
      end
      rest(10);

      // R9: general-purpose mode in mid blink
      speed_100 = 1'b1;
      step();
      tx_act = 1'b1; step(); tx_act = 1'b0;
      for (int k = 1; k <= 30; k++) begin
         rx_act = (k == 2);
         if (k == 4) gpio_mode = 1'b1;
         if (k == 9) gpio_mode = 1'b0;
         step();
         rx_act = 1'b0;
         chk(led_pin[1], (k <= 8), "R9 gpio holds sequencer");
         chk(led_pin[0], (k >= 4 && k <= 8), "R9 gpio releases speed");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule